// File: doc/BRIEF.md
# ADC conversion sequencer

This block is the digital side of a 10-bit successive-approximation converter. Software reaches it through a small register bus. It uses those registers to switch the converter on, start a conversion, choose the ADC clock rate, and select the channel and reference. The block derives an ADC clock tick from the system clock and counts the ADC clocks of each conversion. When the last cycle ends, it takes the converted value from its result input and raises a completion flag. It also drives an interrupt request while that flag and the interrupt enable are both set.

Channel, reference and clock-rate settings are copied into working registers when a conversion starts. A write to any of them during a conversion therefore applies only from the next conversion. The first conversion after the block is enabled is a longer initialization run. Turning the block off during a conversion abandons it.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset, all four registers read zero, and `busy`, `irq`, `conv_chan` and `conv_ref` are zero.
- R2: Register map (2-bit address, read data is combinational):
  - Offset 0 is control. Bit 0 is enable, bit 1 is start (it reads as busy), bit 2 is the completion flag, bit 3 is the interrupt enable and bits 6:4 are the prescale code.
  - Offset 1 is the selection register, with the channel in bits 3:0 and the reference in bits 5:4. It reads back the last written value.
  - Offset 2 holds result bits 7:0.
  - Offset 3 holds result bits 9:8 in bits 1:0.
- R3: Prescale code 0 divides the system clock by 2, and code c from 1 to 7 divides it by 2^c. A conversion keeps `busy` high for its ADC clock count times that divisor, in system cycles.
- R4: The first conversion after enable lasts 25 ADC clocks. This includes a start written in the same write as enable. Every later conversion lasts 13 ADC clocks. `busy` rises in the cycle after the accepted start write.
- R5: A start is accepted only when the written enable bit is 1 and no conversion is running. Writing 0 to the start bit does nothing. A start written during a conversion is dropped, not queued.
- R6: Writing enable as 0 ends a running conversion: `busy` is low in the next cycle, the flag and result are left unchanged, and the next conversion is again an initialization run of 25 ADC clocks.
- R7: `conv_chan` and `conv_ref` take the selection register's value when a start is accepted, and hold it until the next accepted start.
- R8: At the final system cycle of a conversion, the block captures `adc_result` into the result register and sets the flag.
- R9: The flag is cleared by a control write with bit 2 set, or by an `irq_ack` pulse. A control write with bit 2 clear leaves the flag as it is. When a completion lands in the same cycle as a clear, the flag ends up set.
- R10: `irq` is high exactly when the flag and the interrupt enable are both 1.
- R11: The prescale divisor is captured when a start is accepted. Changing the prescale code during a conversion does not change that conversion's length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 1 | Bus access strobe |
| bus_we | input | 1 | Write qualifier for the access |
| bus_addr | input | 2 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| adc_result | input | 10 | Converted value from the analog side |
| irq_ack | input | 1 | Interrupt acknowledge pulse, clears the flag |
| irq | output | 1 | Interrupt request |
| busy | output | 1 | Conversion in progress |
| conv_chan | output | 4 | Channel applied to the running conversion |
| conv_ref | output | 2 | Reference applied to the running conversion |

## Verification
The case that matters most is the end of a conversion falling on the same edge as a flag clear, whether the clear comes from a write-one to the flag bit or from an acknowledge pulse. The bench counts the conversion length and times the clear so that the bus write, or the `irq_ack` pulse, is sampled on the final counting edge. It then judges the outcome by the flag reading back as one and `irq` staying high, since a completion must never be lost. A second coincidence checks that a start written during a conversion is neither honoured nor remembered, and that a prescale change made mid-conversion does not alter that conversion's measured length.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    localparam int unsigned BUS_ADDR_W     = 2;

    localparam int unsigned CTRL_EN_BIT    = 0;
    localparam int unsigned CTRL_START_BIT = 1;
    localparam int unsigned CTRL_FLAG_BIT  = 2;
    localparam int unsigned CTRL_IE_BIT    = 3;
    localparam int unsigned CTRL_PSC_LSB   = 4;

    typedef enum logic [BUS_ADDR_W-1:0] {
        ADDR_CTRL   = 2'd0,
        ADDR_SEL    = 2'd1,
        ADDR_RES_LO = 2'd2,
        ADDR_RES_HI = 2'd3
    } adc_addr_e;

    // Code 0 and code 1 both give the smallest divide factor.
    function automatic int unsigned psc_div(input int unsigned code);
        return (code == 0) ? 2 : (32'd1 << code);
    endfunction

endpackage

// File: rtl/adc_seq_regs.sv
module adc_seq_regs
    import adc_seq_pkg::*;
#(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned RES_W  = 10,
    parameter int unsigned CHAN_W = 4,
    parameter int unsigned REF_W  = 2,
    parameter int unsigned PSC_W  = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_sel,
    input  logic                  bus_we,
    input  logic [BUS_ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0]     bus_wdata,
    output logic [DATA_W-1:0]     bus_rdata,
    input  logic [RES_W-1:0]      adc_result,
    input  logic                  irq_ack,
    input  logic                  busy,
    input  logic                  done,
    output logic                  en_next,
    output logic [PSC_W-1:0]      psc_next,
    output logic                  start_req,
    output logic [CHAN_W-1:0]     sel_chan,
    output logic [REF_W-1:0]      sel_ref,
    output logic                  flag,
    output logic                  irq
);

    localparam int unsigned HI_W   = RES_W - DATA_W;
    localparam int unsigned CTRL_W = CTRL_PSC_LSB + PSC_W;

    typedef struct packed {
        logic              en;
        logic              ie;
        logic              flag;
        logic [PSC_W-1:0]  psc;
        logic [CHAN_W-1:0] chan;
        logic [REF_W-1:0]  refsel;
        logic [RES_W-1:0]  res;
    } regs_t;

    regs_t st_d, st_q;
    logic  wr_ctrl, wr_sel, flag_clr;
    logic  wdata_unused;

    assign wdata_unused = ^bus_wdata[DATA_W-1:CTRL_W];

    always_comb begin
        st_d     = st_q;
        wr_ctrl  = bus_sel && bus_we && (bus_addr == ADDR_CTRL);
        wr_sel   = bus_sel && bus_we && (bus_addr == ADDR_SEL);
        flag_clr = irq_ack || (wr_ctrl && bus_wdata[CTRL_FLAG_BIT]);

        if (wr_ctrl) begin
            st_d.en  = bus_wdata[CTRL_EN_BIT];
            st_d.ie  = bus_wdata[CTRL_IE_BIT];
            st_d.psc = bus_wdata[CTRL_PSC_LSB +: PSC_W];
        end
        if (wr_sel) begin
            st_d.chan   = bus_wdata[CHAN_W-1:0];
            st_d.refsel = bus_wdata[CHAN_W +: REF_W];
        end

        // A finishing conversion outranks any clear in the same cycle.
        if (done) begin
            st_d.flag = 1'b1;
            st_d.res  = adc_result;
        end else if (flag_clr) begin
            st_d.flag = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        unique case (bus_addr)
            ADDR_CTRL:   bus_rdata = DATA_W'({st_q.psc, st_q.ie, st_q.flag, busy, st_q.en});
            ADDR_SEL:    bus_rdata = DATA_W'({st_q.refsel, st_q.chan});
            ADDR_RES_LO: bus_rdata = st_q.res[DATA_W-1:0];
            default:     bus_rdata = DATA_W'(st_q.res[DATA_W +: HI_W]);
        endcase
    end

    assign en_next   = st_d.en;
    assign psc_next  = st_d.psc;
    assign start_req = wr_ctrl && bus_wdata[CTRL_START_BIT];
    assign sel_chan  = st_q.chan;
    assign sel_ref   = st_q.refsel;
    assign flag      = st_q.flag;
    assign irq       = st_q.flag && st_q.ie;

endmodule

// File: rtl/adc_seq_timer.sv
module adc_seq_timer
    import adc_seq_pkg::*;
#(
    parameter int unsigned CHAN_W     = 4,
    parameter int unsigned REF_W      = 2,
    parameter int unsigned PSC_W      = 3,
    parameter int unsigned NORMAL_CYC = 13,
    parameter int unsigned INIT_CYC   = 25
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_next,
    input  logic              start_req,
    input  logic [PSC_W-1:0]  psc_next,
    input  logic [CHAN_W-1:0] sel_chan,
    input  logic [REF_W-1:0]  sel_ref,
    output logic              busy,
    output logic              done,
    output logic [CHAN_W-1:0] conv_chan,
    output logic [REF_W-1:0]  conv_ref
);

    localparam int unsigned MAX_CODE = (1 << PSC_W) - 1;
    localparam int unsigned MAX_DIV  = psc_div(MAX_CODE);
    localparam int unsigned PCNT_W   = $clog2(MAX_DIV);
    localparam int unsigned CYC_W    = $clog2(INIT_CYC);

    typedef struct packed {
        logic              busy;
        logic              init_done;
        logic [PCNT_W-1:0] pcnt;
        logic [PCNT_W-1:0] divm1;
        logic [CYC_W-1:0]  ccnt;
        logic [CYC_W-1:0]  last;
        logic [CHAN_W-1:0] chan;
        logic [REF_W-1:0]  refsel;
    } tmr_t;

    tmr_t st_d, st_q;
    logic adc_tick, last_cyc;

    assign adc_tick = (st_q.pcnt == st_q.divm1);
    assign last_cyc = (st_q.ccnt == st_q.last);
    assign done     = st_q.busy && en_next && adc_tick && last_cyc;

    always_comb begin
        st_d = st_q;
        if (!en_next) begin
            st_d.busy      = 1'b0;
            st_d.init_done = 1'b0;
            st_d.pcnt      = '0;
            st_d.ccnt      = '0;
        end else if (st_q.busy) begin
            if (adc_tick) begin
                st_d.pcnt = '0;
                if (last_cyc) begin
                    st_d.busy      = 1'b0;
                    st_d.init_done = 1'b1;
                    st_d.ccnt      = '0;
                end else begin
                    st_d.ccnt = st_q.ccnt + CYC_W'(1);
                end
            end else begin
                st_d.pcnt = st_q.pcnt + PCNT_W'(1);
            end
        end else if (start_req) begin
            st_d.busy   = 1'b1;
            st_d.pcnt   = '0;
            st_d.ccnt   = '0;
            st_d.last   = st_q.init_done ? CYC_W'(NORMAL_CYC - 1) : CYC_W'(INIT_CYC - 1);
            st_d.divm1  = PCNT_W'(psc_div(32'(psc_next)) - 1);
            st_d.chan   = sel_chan;
            st_d.refsel = sel_ref;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy      = st_q.busy;
    assign conv_chan = st_q.chan;
    assign conv_ref  = st_q.refsel;

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int unsigned DATA_W     = 8,
    parameter int unsigned RES_W      = 10,
    parameter int unsigned CHAN_W     = 4,
    parameter int unsigned REF_W      = 2,
    parameter int unsigned PSC_W      = 3,
    parameter int unsigned NORMAL_CYC = 13,
    parameter int unsigned INIT_CYC   = 25
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_sel,
    input  logic                  bus_we,
    input  logic [BUS_ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0]     bus_wdata,
    output logic [DATA_W-1:0]     bus_rdata,
    input  logic [RES_W-1:0]      adc_result,
    input  logic                  irq_ack,
    output logic                  irq,
    output logic                  busy,
    output logic [CHAN_W-1:0]     conv_chan,
    output logic [REF_W-1:0]      conv_ref
);

    logic              en_next_w, start_req_w, done_w, flag_w;
    logic [PSC_W-1:0]  psc_next_w;
    logic [CHAN_W-1:0] sel_chan_w;
    logic [REF_W-1:0]  sel_ref_w;

    adc_seq_regs #(
        .DATA_W (DATA_W),
        .RES_W  (RES_W),
        .CHAN_W (CHAN_W),
        .REF_W  (REF_W),
        .PSC_W  (PSC_W)
    ) regs_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_sel    (bus_sel),
        .bus_we     (bus_we),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .adc_result (adc_result),
        .irq_ack    (irq_ack),
        .busy       (busy),
        .done       (done_w),
        .en_next    (en_next_w),
        .psc_next   (psc_next_w),
        .start_req  (start_req_w),
        .sel_chan   (sel_chan_w),
        .sel_ref    (sel_ref_w),
        .flag       (flag_w),
        .irq        (irq)
    );

    adc_seq_timer #(
        .CHAN_W     (CHAN_W),
        .REF_W      (REF_W),
        .PSC_W      (PSC_W),
        .NORMAL_CYC (NORMAL_CYC),
        .INIT_CYC   (INIT_CYC)
    ) timer_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_next   (en_next_w),
        .start_req (start_req_w),
        .psc_next  (psc_next_w),
        .sel_chan  (sel_chan_w),
        .sel_ref   (sel_ref_w),
        .busy      (busy),
        .done      (done_w),
        .conv_chan (conv_chan),
        .conv_ref  (conv_ref)
    );

endmodule

// File: rtl/adc_seq_ctrl_chk.sv
module adc_seq_ctrl_chk #(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned CHAN_W = 4,
    parameter int unsigned REF_W  = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_we,
    input logic [1:0]        bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              irq_ack,
    input logic              irq,
    input logic              busy,
    input logic [CHAN_W-1:0] conv_chan,
    input logic [REF_W-1:0]  conv_ref,
    input logic              done,
    input logic              flag
);

    AST_ABORT_CLEARS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_we && bus_addr == 2'd0 && !bus_wdata[0]) |=> !busy); // R6

    AST_CONV_SEL_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ($stable(conv_chan) && $stable(conv_ref))); // R7

    AST_DONE_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> flag); // R8

    AST_FLAG_ONLY_FROM_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> $past(done)); // R8

    AST_DONE_NOT_REQUEUED: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy); // R5

    AST_ACK_DROPS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack && !done) |=> !irq); // R9

endmodule

bind adc_seq_ctrl adc_seq_ctrl_chk #(
    .DATA_W (DATA_W),
    .CHAN_W (CHAN_W),
    .REF_W  (REF_W)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .irq_ack   (irq_ack),
    .irq       (irq),
    .busy      (busy),
    .conv_chan (conv_chan),
    .conv_ref  (conv_ref),
    .done      (done_w),
    .flag      (flag_w)
);

// File: tb/adc_seq_ctrl_tb_top.sv
`timescale 1ns/1ps
module adc_seq_ctrl_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_sel = 1'b0, bus_we = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic [9:0] adc_result = 10'd0;
    logic       irq_ack = 1'b0;
    logic       irq, busy;
    logic [3:0] conv_chan;
    logic [1:0] conv_ref;

    int checks = 0, errors = 0, cycles = 0;
    int cur_len = 0, last_len = 0;

    always #10 clk = ~clk;

    adc_seq_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .adc_result(adc_result), .irq_ack(irq_ack), .irq(irq), .busy(busy),
        .conv_chan(conv_chan), .conv_ref(conv_ref)
    );

    task automatic chk(input int act, input int exp, input string tag);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Reference model state
    int m_en, m_ie, m_flag, m_psc, m_busy, m_remain, m_init;
    int m_chan, m_ref, m_cchan, m_cref, m_res;
    int en_n, psc_n, clr, dn, wr_c, wr_s;

    function automatic int divf(input int c);
        return (c == 0) ? 2 : (1 << c);
    endfunction

    function automatic int mread(input int a);
        case (a)
            0: return (m_psc << 4) | (m_ie << 3) | (m_flag << 2) | (m_busy << 1) | m_en;
            1: return (m_ref << 4) | m_chan;
            2: return m_res & 255;
            default: return m_res >> 8;
        endcase
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_en = 0; m_ie = 0; m_flag = 0; m_psc = 0; m_busy = 0; m_remain = 0;
            m_init = 0; m_chan = 0; m_ref = 0; m_cchan = 0; m_cref = 0; m_res = 0;
        end else begin
            // compare pre-edge outputs with pre-edge model state
            chk(busy, m_busy, "R4 busy per cycle");
            chk(irq, (m_flag != 0 && m_ie != 0) ? 1 : 0, "R10 irq per cycle");
            chk(conv_chan, m_cchan, "R7 conv_chan per cycle");
            chk(conv_ref, m_cref, "R7 conv_ref per cycle");
            chk(bus_rdata, mread(bus_addr),
                bus_addr == 0 ? "R9 ctrl readback" : bus_addr == 1 ? "R2 sel readback" : "R8 result readback");
            wr_c  = (bus_sel && bus_we && bus_addr == 2'd0) ? 1 : 0;
            wr_s  = (bus_sel && bus_we && bus_addr == 2'd1) ? 1 : 0;
            en_n  = wr_c ? int'(bus_wdata[0]) : m_en;
            psc_n = wr_c ? int'(bus_wdata[6:4]) : m_psc;
            clr   = ((wr_c && bus_wdata[2]) || irq_ack) ? 1 : 0;
            dn    = (m_busy && en_n && m_remain == 1) ? 1 : 0;
            if (!en_n) begin
                m_busy = 0; m_init = 0;
            end else if (m_busy) begin
                m_remain--;
                if (m_remain == 0) begin m_busy = 0; m_init = 1; end
            end else if (wr_c && bus_wdata[1]) begin
                m_busy = 1;
                m_remain = (m_init ? 13 : 25) * divf(psc_n);
                m_cchan = m_chan; m_cref = m_ref;
            end
            if (dn) begin m_flag = 1; m_res = adc_result; end
            else if (clr) m_flag = 0;
            if (wr_c) begin m_en = en_n; m_ie = bus_wdata[3]; m_psc = psc_n; end
            if (wr_s) begin m_chan = bus_wdata[3:0]; m_ref = bus_wdata[5:4]; end
        end
    end

    // busy run-length monitor
    always @(negedge clk) begin
        if (busy) cur_len++;
        else if (cur_len != 0) begin last_len = cur_len; cur_len = 0; end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            $display("FAIL watchdog: actual %0d expected below %0d cycles", cycles, 150000);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    function automatic logic [7:0] ctrl(input int en, input int st, input int cl, input int ie, input int psc);
        return {1'b0, psc[2:0], ie[0], cl[0], st[0], en[0]};
    endfunction

    task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output int v);
        bus_addr = a;
        #1;
        v = bus_rdata;
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
        #1;
    endtask

    task automatic run_conv(input logic [7:0] c, input int exp_len, input string tag);
        bus_wr(2'd0, c);
        wait_idle();
        chk(last_len, exp_len, tag);
        @(negedge clk);
    endtask

    int v;

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        for (int a = 0; a < 4; a++) begin
            rd(a[1:0], v);
            chk(v, 0, "R1 register reset value");
        end
        chk(busy, 0, "R1 busy after reset");
        chk(irq, 0, "R1 irq after reset");
        chk(conv_chan, 0, "R1 conv_chan after reset");
        @(negedge clk);

        // R2 selection write and readback
        bus_wr(2'd1, 8'h25);
        rd(2'd1, v);
        chk(v, 8'h25, "R2 selection readback");
        @(negedge clk);

        // R4 first conversion with enable and start together
        adc_result = 10'h2A5;
        run_conv(ctrl(1, 1, 0, 1, 0), 50, "R4 first conversion 25 ADC clocks");
        chk(conv_chan, 5, "R7 channel captured at start");
        chk(conv_ref, 2, "R7 reference captured at start");
        rd(2'd2, v); chk(v, 8'hA5, "R8 result low byte");
        rd(2'd3, v); chk(v, 2, "R8 result high bits");
        rd(2'd0, v); chk((v >> 2) & 1, 1, "R8 flag set at completion");
        chk(irq, 1, "R10 irq with flag and enable");
        @(negedge clk);

        // R9 writing zero to flag keeps it, writing one clears it
        bus_wr(2'd0, ctrl(1, 0, 0, 1, 0));
        chk(irq, 1, "R9 flag kept by write of zero");
        bus_wr(2'd0, ctrl(1, 0, 1, 1, 0));
        chk(irq, 0, "R9 flag cleared by write of one");

        // R3 divisors on normal conversions
        adc_result = 10'h13C;
        run_conv(ctrl(1, 1, 0, 1, 1), 26, "R3 code 1 divide by 2");
        run_conv(ctrl(1, 1, 0, 1, 3), 104, "R3 code 3 divide by 8");
        run_conv(ctrl(1, 1, 0, 1, 7), 1664, "R3 code 7 divide by 128");
        rd(2'd2, v); chk(v, 8'h3C, "R8 second result low byte");

        // R9 acknowledge pulse clears flag
        irq_ack = 1'b1; @(negedge clk); irq_ack = 1'b0;
        chk(irq, 0, "R9 flag cleared by acknowledge");

        // R10 interrupt enable off
        run_conv(ctrl(1, 1, 1, 0, 0), 26, "R4 normal conversion");
        chk(irq, 0, "R10 no irq with enable clear");
        bus_wr(2'd0, ctrl(1, 0, 0, 1, 0));
        chk(irq, 1, "R10 irq once enable set");
        bus_wr(2'd0, ctrl(1, 0, 1, 1, 0));

        // R5 write of zero to start, and start without enable
        bus_wr(2'd0, ctrl(1, 0, 0, 1, 0));
        chk(busy, 0, "R5 zero start bit has no effect");
        bus_wr(2'd0, ctrl(0, 1, 0, 1, 0));
        chk(busy, 0, "R5 start ignored with enable clear");

        // R7 R11 R5 writes during a running conversion
        bus_wr(2'd0, ctrl(1, 1, 0, 1, 0));
        bus_wr(2'd1, 8'h19);
        bus_wr(2'd0, ctrl(1, 1, 0, 1, 5));
        chk(conv_chan, 5, "R7 channel held during conversion");
        wait_idle();
        chk(last_len, 50, "R11 divisor held during conversion");
        @(negedge clk);
        chk(busy, 0, "R5 start during conversion not queued");
        run_conv(ctrl(1, 1, 1, 1, 5), 416, "R11 new divisor on next conversion");
        chk(conv_chan, 9, "R7 new channel on next conversion");
        chk(conv_ref, 1, "R7 new reference on next conversion");

        // R6 abort
        bus_wr(2'd0, ctrl(1, 0, 1, 1, 0));
        adc_result = 10'h3FF;
        bus_wr(2'd0, ctrl(1, 1, 0, 1, 0));
        repeat (10) @(negedge clk);
        bus_wr(2'd0, ctrl(0, 0, 0, 1, 0));
        chk(busy, 0, "R6 busy drops on disable");
        rd(2'd0, v); chk((v >> 2) & 1, 0, "R6 no flag after abort");
        rd(2'd2, v); chk(v, 8'h3C, "R6 result unchanged after abort");
        @(negedge clk);
        run_conv(ctrl(1, 1, 0, 1, 0), 50, "R6 initialization run after re-enable");

        // R9 completion and write-clear in the same cycle
        bus_wr(2'd0, ctrl(1, 1, 1, 1, 0));
        repeat (25) @(negedge clk);
        bus_wr(2'd0, ctrl(1, 0, 1, 1, 0));
        rd(2'd0, v); chk((v >> 2) & 1, 1, "R9 completion wins over write clear");
        chk(irq, 1, "R9 irq after coincident write clear");

        // R9 completion and acknowledge in the same cycle
        bus_wr(2'd0, ctrl(1, 1, 1, 1, 0));
        repeat (25) @(negedge clk);
        irq_ack = 1'b1; @(negedge clk); irq_ack = 1'b0;
        rd(2'd0, v); chk((v >> 2) & 1, 1, "R9 completion wins over acknowledge");
        chk(irq, 1, "R9 irq after coincident acknowledge");

        repeat (3) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule